// File: doc/BRIEF.md
# Signature and Test Pattern Unit

This block is the data engine behind a set of extended boundary-test operations on an 18-bit I/O boundary. One shift register is reused for four jobs: it compresses sampled input data into a parallel signature, it runs as a pseudo-random pattern source, it counts upward in binary, or it inverts its held value while the input values are captured into a second register. A test controller outside the block selects the job with a 3-bit mode code. It advances the register with a one-cycle step strobe, which it raises once for each selected update event.

In the three driving modes (pattern, count, toggle) the register value replaces the functional data on the output boundary. In every other mode the functional value passes straight through. Both registers can be read and preloaded serially through a one-bit shift path. This path is how a signature is unloaded and how a seed is planted.

Top module: `sig_pattern_unit`

## Requirements
- R1: After reset the signature register holds 000001 hex and the capture register holds zero. Serial output and the boundary in mode 0 reflect this.
- R2: The registers change only on a cycle with the step strobe high and a mode code of 1 to 4, or on a shift cycle. On all other cycles they hold their value.
- R3: Mode 1 (signature) with a step loads lfsr(sig) XOR sampleIn. Here lfsr(r) = {r[16:0], r[17]^r[10]}.
- R4: Mode 2 (pattern) with a step loads lfsr(sig). If the register is all zero, the step loads 000001 hex instead, so the sequence cannot lock up.
- R5: Mode 3 (count) with a step adds one to the register, and all ones wraps to zero.
- R6: Mode 4 (toggle) with a step inverts the signature register and loads sampleIn into the capture register.
- R7: boundOut equals the signature register in modes 2, 3 and 4. In all other modes it equals sysOut.
- R8: When scanShift is high and no step is taken, the selected register shifts right with scanIn entering bit 17. The capture register is selected in mode 4 and the signature register otherwise. scanOut always shows bit 0 of the selected register. A step taken in the same cycle wins, and the shift is ignored.
- R9: Codes 5 to 7 behave like mode 0: a step has no effect and the boundary passes sysOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Test mode code (0 off, 1 signature, 2 pattern, 3 count, 4 toggle) |
| stepStb | input | 1 | One-cycle advance strobe |
| scanShift | input | 1 | Serial shift enable |
| scanIn | input | 1 | Serial data into bit 17 |
| sampleIn | input | 18 | Values sampled at the input boundary |
| sysOut | input | 18 | Functional output value |
| boundOut | output | 18 | Value driven to the output boundary |
| scanOut | output | 1 | Bit 0 of the selected register |

## Verification
In a driving mode, a wrong register value appears on boundOut in the cycle after the faulty step. Every later step then carries the error forward, because each next value is computed from the current one. In signature or off mode the fault stays hidden from the boundary. It surfaces on scanOut, at the latest after 18 shift cycles, which the bench uses to unload and preload the register. A wrong choice of scan chain or step priority shows on scanOut one cycle after the shift.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_PSA    = 3'd1,
    MODE_PRPG   = 3'd2,
    MODE_COUNT  = 3'd3,
    MODE_TOGGLE = 3'd4
  } spuMode_e;

  typedef struct packed {
    logic advPsa;
    logic advPrpg;
    logic advCount;
    logic advToggle;
    logic shiftSig;
    logic shiftCap;
    logic selCap;
    logic drivePattern;
  } spuCtl_t;
endpackage

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    modeSel,
  input  logic          stepStb,
  input  logic          scanShift,
  output spuCtl_t       ctl
);
  logic isPsa, isPrpg, isCount, isToggle, advance, shiftReq;

  always_comb begin
    isPsa    = (modeSel == MODE_PSA);
    isPrpg   = (modeSel == MODE_PRPG);
    isCount  = (modeSel == MODE_COUNT);
    isToggle = (modeSel == MODE_TOGGLE);
    advance  = stepStb && (isPsa || isPrpg || isCount || isToggle);
    shiftReq = scanShift && !advance;
    ctl.advPsa       = stepStb && isPsa;
    ctl.advPrpg      = stepStb && isPrpg;
    ctl.advCount     = stepStb && isCount;
    ctl.advToggle    = stepStb && isToggle;
    ctl.shiftSig     = shiftReq && !isToggle;
    ctl.shiftCap     = shiftReq && isToggle;
    ctl.selCap       = isToggle;
    ctl.drivePattern = isPrpg || isCount || isToggle;
  end

  // R2 / R8: at most one register action per cycle
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.advPsa, ctl.advPrpg, ctl.advCount, ctl.advToggle, ctl.shiftSig, ctl.shiftCap}));

  // R9: reserved codes never advance
  p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel > 3'd4) |-> !(ctl.advPsa || ctl.advPrpg || ctl.advCount || ctl.advToggle));
endmodule

// File: rtl/spu_datapath.sv
module spu_datapath
  import spu_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int TAP_B = 10,
  parameter logic [WIDTH-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  spuCtl_t          ctl,
  input  logic             scanIn,
  input  logic [WIDTH-1:0] sampleIn,
  output logic [WIDTH-1:0] sigValue,
  output logic             scanOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sigReg, capReg, lfsrNext;

  always_comb begin
    lfsrNext = {sigReg[MSB-1:0], sigReg[MSB] ^ sigReg[TAP_B]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigReg <= SEED;
    end else if (ctl.advPsa) begin
      sigReg <= lfsrNext ^ sampleIn;
    end else if (ctl.advPrpg) begin
      sigReg <= (sigReg == '0) ? SEED : lfsrNext;
    end else if (ctl.advCount) begin
      sigReg <= sigReg + 1'b1;
    end else if (ctl.advToggle) begin
      sigReg <= ~sigReg;
    end else if (ctl.shiftSig) begin
      sigReg <= {scanIn, sigReg[MSB:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (ctl.advToggle) begin
      capReg <= sampleIn;
    end else if (ctl.shiftCap) begin
      capReg <= {scanIn, capReg[MSB:1]};
    end
  end

  assign sigValue = sigReg;
  assign scanOut  = ctl.selCap ? capReg[0] : sigReg[0];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.advPsa || ctl.advPrpg || ctl.advCount || ctl.advToggle || ctl.shiftSig) |=> $stable(sigReg));

  p_no_lockup_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advPrpg |=> sigReg != '0);

  p_count_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advCount && sigReg == '1) |=> sigReg == '0);

  p_toggle_invert_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advToggle |=> sigReg == ~$past(sigReg));

  p_shift_in_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftSig |=> sigReg[MSB] == $past(scanIn));
endmodule

// File: rtl/sig_pattern_unit.sv
module sig_pattern_unit
  import spu_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic             stepStb,
  input  logic             scanShift,
  input  logic             scanIn,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic [WIDTH-1:0] sysOut,
  output logic [WIDTH-1:0] boundOut,
  output logic             scanOut
);
  spuCtl_t          ctl;
  logic [WIDTH-1:0] sigValue;

  spu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stepStb(stepStb),
    .scanShift(scanShift), .ctl(ctl)
  );

  spu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .scanIn(scanIn),
    .sampleIn(sampleIn), .sigValue(sigValue), .scanOut(scanOut)
  );

  assign boundOut = ctl.drivePattern ? sigValue : sysOut;

  // R7 / R9: non-driving codes pass the functional value
  p_passthru_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 || modeSel == 3'd1 || modeSel > 3'd4) |-> boundOut == sysOut);
endmodule

// File: tb/sim_sig_pattern_unit.sv
module sim_sig_pattern_unit;
  localparam int W = 18;

  logic clk = 0, rstN = 0;
  logic [2:0] modeSel = 0;
  logic stepStb = 0, scanShift = 0, scanIn = 0;
  logic [W-1:0] sampleIn = 0, sysOut = 0;
  logic [W-1:0] boundOut;
  logic scanOut;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [W-1:0] sigM, capM;

  sig_pattern_unit u0 (.*);

  always #10 clk = ~clk;

  function automatic logic [W-1:0] lfsr(input logic [W-1:0] r);
    return {r[W-2:0], r[W-1] ^ r[10]};
  endfunction

  function automatic bit drives(input logic [2:0] m);
    return (m == 3'd2 || m == 3'd3 || m == 3'd4);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit adv;
    adv = stepStb && modeSel >= 3'd1 && modeSel <= 3'd4;
    if (adv) begin
      case (modeSel)
        3'd1: sigM = lfsr(sigM) ^ sampleIn;
        3'd2: sigM = (sigM == 0) ? W'(1) : lfsr(sigM);
        3'd3: sigM = sigM + 1'b1;
        default: begin sigM = ~sigM; capM = sampleIn; end
      endcase
    end else if (scanShift) begin
      if (modeSel == 3'd4) capM = {scanIn, capM[W-1:1]};
      else sigM = {scanIn, sigM[W-1:1]};
    end
  endtask

  task automatic cyc(input logic [2:0] m, input logic st, input logic sh, input logic si,
                     input logic [W-1:0] samp, input logic [W-1:0] sys);
    string tag;
    modeSel = m; stepStb = st; scanShift = sh; scanIn = si; sampleIn = samp; sysOut = sys;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    if (st && m == 3'd1) tag = "R3";
    else if (st && m == 3'd2) tag = "R4";
    else if (st && m == 3'd3) tag = "R5";
    else if (st && m == 3'd4) tag = "R6";
    else if (st) tag = "R9";
    else if (sh) tag = "R8";
    else tag = "R2";
    check({tag, " boundOut (R7)"}, boundOut, drives(m) ? sigM : sys);
    check({tag, " scanOut"}, W'(scanOut), W'(m == 3'd4 ? capM[0] : sigM[0]));
  endtask

  task automatic loadSig(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) cyc(3'd0, 1'b0, 1'b1, v[i], '0, '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    sigM = 1; capM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    sysOut = 18'h2a5a5;
    #1;
    check("R1 scanOut after reset", W'(scanOut), W'(1));
    check("R1 boundOut off mode", boundOut, 18'h2a5a5);

    // R5 wrap from all ones
    loadSig('1);
    check("R8 serial preload", boundOut, '0);
    cyc(3'd3, 1'b1, 1'b0, 1'b0, '0, '0);
    check("R5 count wraps to zero", boundOut, '0);

    // R4 zero escape
    loadSig('0);
    cyc(3'd2, 1'b1, 1'b0, 1'b0, '0, '0);
    check("R4 zero escapes to seed", boundOut, 18'h00001);
    cyc(3'd2, 1'b1, 1'b0, 1'b0, '0, '0);
    check("R4 pattern next", boundOut, 18'h00002);

    // R8 step wins over shift
    cyc(3'd2, 1'b1, 1'b1, 1'b1, '0, '0);
    check("R8 step priority", boundOut, 18'h00004);

    // R9 reserved code ignores step
    cyc(3'd6, 1'b1, 1'b0, 1'b0, '1, 18'h13579);
    cyc(3'd2, 1'b0, 1'b0, 1'b0, '0, '0);
    check("R9 reserved step no effect", boundOut, 18'h00004);

    // R3 signature directed
    cyc(3'd1, 1'b1, 1'b0, 1'b0, 18'h30003, 18'h11111);
    cyc(3'd2, 1'b0, 1'b0, 1'b0, '0, '0);
    check("R3 signature value", boundOut, 18'h3000b);

    // R6 toggle and capture readback
    cyc(3'd4, 1'b1, 1'b0, 1'b0, 18'h2aaab, '0);
    check("R6 toggled output", boundOut, ~18'h3000b);
    check("R6 capture bit0", W'(scanOut), W'(1));

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      cyc(m, 1'($urandom), 1'($urandom), 1'($urandom), W'($urandom), W'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule